// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This unit performs Q15 by Q15 fixed-point multiplication with accumulation into a Q31 value. It handles both multiply-accumulate and multiply-subtract. Each operation takes two signed 16-bit operands and an add/subtract select. A 32-bit accumulator value supplied one cycle later is combined with the doubled product. The unit returns a saturated 32-bit result together with an overflow flag. A new operation may start on every clock. A valid bit travels through the two pipeline stages with the data.

Stage one forms the doubled signed product. In subtract mode it stores the bitwise inverse of that product. It also flags the single operand pair whose doubled product does not fit. Stage two builds two candidate sums in parallel. The first uses the true product and the second uses the largest positive value (or its inverse when subtracting). The output is then chosen from these two sums and the two saturation limits. The accumulator is storage outside this unit. Because the accumulator is sampled in the second stage, a result can be fed back as the accumulator of the operation issued right after it.

Top module: `frac_macsu`

## Requirements
- R1: In add mode (sub_i = 0) with no overflow, res_o equals acc_i + 2*op_a*op_b as a signed 32-bit value, and ovf_o is 0.
- R2: In subtract mode (sub_i = 1) with no overflow, res_o equals acc_i - 2*op_a*op_b, and ovf_o is 0.
- R3: When both operands are -32768, the doubled product is taken as 0x7FFFFFFF and ovf_o is 1. The result is acc_i + 0x7FFFFFFF (add mode) or acc_i - 0x7FFFFFFF (subtract mode), saturated as in R4.
- R4: When the accumulate or subtract overflows the signed 32-bit range, res_o is 0x7FFFFFFF if acc_i is non-negative and 0x80000000 if acc_i is negative, and ovf_o is 1.
- R5: ovf_o is the OR of the product overflow and the accumulate overflow. It is 1 only while out_valid is 1.
- R6: Operands, sub_i and in_valid are sampled on clock edge N. acc_i is sampled on edge N+1, and res_o, ovf_o and out_valid update on edge N+1. An operation can be issued on every edge, and out_valid is 0 after an edge on which no operation completes.
- R7: While rst_n is low, out_valid, ovf_o and res_o are all 0.
- R8: The res_o of an operation, driven back as acc_i, is used by the operation issued on the next edge, so dependent accumulations run without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present on op_a/op_b/sub_i |
| sub_i | input | 1 | 0 = accumulate, 1 = subtract product |
| op_a | input | OPW | Signed Q15 multiplicand |
| op_b | input | OPW | Signed Q15 multiplier |
| acc_i | input | 2*OPW | Signed Q31 accumulator, one cycle after the operands |
| res_o | output | 2*OPW | Saturated Q31 result |
| ovf_o | output | 1 | Overflow of product or accumulate |
| out_valid | output | 1 | res_o and ovf_o are meaningful |

## Verification
The operands of an operation are driven before edge N and its accumulator before edge N+1. Its result, flag and valid are due after edge N+1, so the bench compares them at the falling edge that follows. The bench streams operations one per cycle. At each falling edge it checks the operation issued two falling edges earlier, applies the accumulator of the previous one and presents the next operands. In the feedback run, the result just checked is driven back as the next accumulator at that same falling edge. The expected results come from a wide-integer model of doubled multiply followed by a saturating add or subtract.

// File: rtl/frac_macsu.sv
`timescale 1ns/1ps
module frac_macsu #(
  parameter int OPW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              sub_i,
  input  logic [OPW-1:0]    op_a,
  input  logic [OPW-1:0]    op_b,
  input  logic [2*OPW-1:0]  acc_i,
  output logic [2*OPW-1:0]  res_o,
  output logic              ovf_o,
  output logic              out_valid
);
  localparam int AW = 2*OPW;
  localparam int MSB = AW-1;
  localparam logic [AW-1:0] MAXV  = {1'b0, {(AW-1){1'b1}}};
  localparam logic [AW-1:0] MINV  = ~MAXV;
  localparam logic [AW-1:0] OVRAW = {2'b01, {(AW-2){1'b0}}};

  logic signed [AW-1:0] raw;
  logic [AW-1:0] dbl;
  logic [AW-1:0] prod_q;
  logic povf_q, sub_q, v1_q;

  assign raw = $signed(op_a) * $signed(op_b);
  assign dbl = {raw[AW-2:0], 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      povf_q <= 1'b0;
      sub_q  <= 1'b0;
      v1_q   <= 1'b0;
    end else begin
      prod_q <= sub_i ? ~dbl : dbl;
      povf_q <= (raw == OVRAW);
      sub_q  <= sub_i;
      v1_q   <= in_valid;
    end
  end

  logic [AW-1:0] sat_opnd, sum1, sum2, pick;
  logic ovf1, ovf2, flag;

  assign sat_opnd = sub_q ? MINV : MAXV;
  assign sum1 = acc_i + prod_q   + {{(AW-1){1'b0}}, sub_q};
  assign sum2 = acc_i + sat_opnd + {{(AW-1){1'b0}}, sub_q};
  assign ovf1 = (acc_i[MSB] == prod_q[MSB])   && (sum1[MSB] != acc_i[MSB]);
  assign ovf2 = (acc_i[MSB] == sat_opnd[MSB]) && (sum2[MSB] != acc_i[MSB]);
  assign flag = povf_q | ovf1;

  always_comb begin
    if (!flag)                 pick = sum1;
    else if (povf_q && !ovf2)  pick = sum2;
    else if (!acc_i[MSB])      pick = MAXV;
    else                       pick = MINV;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o     <= '0;
      ovf_o     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      res_o     <= pick;
      ovf_o     <= v1_q & flag;
      out_valid <= v1_q;
    end
  end

  // R6
  valid_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  // R6
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);
  // R3
  prod_ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v1_q && povf_q) |=> ovf_o);
  // R4
  add_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf_o && !$past(povf_q)) |-> (res_o == MAXV || res_o == MINV));
  // R4
  sat_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ovf_o && !$past(povf_q)) |-> (res_o[MSB] == $past(acc_i[MSB])));
  // R5
  flag_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> out_valid);
endmodule

// File: tb/frac_macsu_test.sv
`timescale 1ns/1ps
module frac_macsu_test;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sub_i = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [31:0] acc_i = '0, res_o;
  logic ovf_o, out_valid;
  int checks = 0, errors = 0;

  logic [15:0] oa [16];
  logic [15:0] ob [16];
  logic        os [16];
  logic [31:0] oc [16];
  logic [31:0] er [16];
  logic        ef [16];

  always #4 clk = ~clk;

  frac_macsu uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_i(sub_i),
    .op_a(op_a), .op_b(op_b), .acc_i(acc_i), .res_o(res_o), .ovf_o(ovf_o),
    .out_valid(out_valid));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] a, input logic [15:0] b, input logic sub,
                                input logic [31:0] acc, output logic [31:0] r, output logic f);
    longint p, s;
    logic pf;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    pf = 1'b0;
    if (a == 16'h8000 && b == 16'h8000) begin p = 64'sh7FFFFFFF; pf = 1'b1; end
    s = sub ? longint'($signed(acc)) - p : longint'($signed(acc)) + p;
    if (s > 64'sh7FFFFFFF) begin r = 32'h7FFFFFFF; f = 1'b1; end
    else if (s < -64'sh80000000) begin r = 32'h80000000; f = 1'b1; end
    else begin r = s[31:0]; f = pf; end
  endfunction

  task automatic run_seq(input int n, input bit fb, input string req);
    for (int k = 0; k <= n + 2; k++) begin
      @(negedge clk);
      if (k >= 2 && k - 2 < n) begin
        chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({req, " result"}, res_o, er[k-2]);
        chk({req, " flag"}, {31'd0, ovf_o}, {31'd0, ef[k-2]});
      end
      if (k == n + 2) chk({req, " R6 idle valid"}, {31'd0, out_valid}, 32'd0);
      if (k >= 1 && k - 1 < n) begin
        logic [31:0] av;
        av = (fb && k > 1) ? er[k-2] : oc[k-1];
        model(oa[k-1], ob[k-1], os[k-1], av, er[k-1], ef[k-1]);
        acc_i = (fb && k > 1) ? res_o : oc[k-1];
      end
      if (k < n) begin
        op_a = oa[k]; op_b = ob[k]; sub_i = os[k]; in_valid = 1'b1;
      end else begin
        in_valid = 1'b0; op_a = '0; op_b = '0; sub_i = 1'b0;
      end
    end
  endtask

  task automatic set_op(input int i, input logic [15:0] a, input logic [15:0] b,
                        input logic s, input logic [31:0] c);
    oa[i] = a; ob[i] = b; os[i] = s; oc[i] = c;
  endtask

  task automatic t_reset;
    #1;
    chk("R7 valid", {31'd0, out_valid}, 32'd0);
    chk("R7 flag", {31'd0, ovf_o}, 32'd0);
    chk("R7 result", res_o, 32'd0);
  endtask

  task automatic t_add;
    set_op(0, 16'd3, 16'd5, 1'b0, 32'd100);
    set_op(1, 16'hFFFE, 16'd7, 1'b0, 32'd0);
    set_op(2, 16'h4000, 16'h4000, 1'b0, 32'h10000000);
    set_op(3, 16'h7FFF, 16'h7FFF, 1'b0, 32'hFFFFFFFF);
    set_op(4, 16'h8000, 16'h7FFF, 1'b0, 32'h7FFF0000);
    run_seq(5, 1'b0, "R1");
  endtask

  task automatic t_sub;
    set_op(0, 16'd3, 16'd5, 1'b1, 32'd100);
    set_op(1, 16'hFFFE, 16'd7, 1'b1, 32'd0);
    set_op(2, 16'd0, 16'd1234, 1'b1, 32'h80000000);
    set_op(3, 16'h7FFF, 16'h7FFF, 1'b1, 32'h7FFFFFFF);
    run_seq(4, 1'b0, "R2");
  endtask

  task automatic t_prod_ovf;
    set_op(0, 16'h8000, 16'h8000, 1'b0, 32'd0);
    set_op(1, 16'h8000, 16'h8000, 1'b0, 32'hFFFFFFFB);
    set_op(2, 16'h8000, 16'h8000, 1'b0, 32'd1);
    set_op(3, 16'h8000, 16'h8000, 1'b1, 32'd0);
    set_op(4, 16'h8000, 16'h8000, 1'b1, 32'hFFFFFFFF);
    set_op(5, 16'h8000, 16'h8000, 1'b1, 32'hFFFFFFFE);
    set_op(6, 16'h8000, 16'h8000, 1'b0, 32'h80000000);
    run_seq(7, 1'b0, "R3");
  endtask

  task automatic t_add_ovf;
    set_op(0, 16'd1, 16'd1, 1'b0, 32'h7FFFFFFF);
    set_op(1, 16'd1, 16'd1, 1'b1, 32'h80000000);
    set_op(2, 16'd1, 16'd1, 1'b0, 32'h80000000);
    set_op(3, 16'hFFFF, 16'd1, 1'b0, 32'h80000000);
    set_op(4, 16'hFFFF, 16'd1, 1'b1, 32'h7FFFFFFF);
    set_op(5, 16'd1, 16'd1, 1'b0, 32'h7FFFFFFD);
    run_seq(6, 1'b0, "R4 R5");
  endtask

  task automatic t_feedback;
    for (int i = 0; i < 5; i++) set_op(i, 16'h4000, 16'h4000, 1'b0, 32'd0);
    set_op(5, 16'h4000, 16'h4000, 1'b1, 32'd0);
    set_op(6, 16'h8000, 16'h8000, 1'b1, 32'd0);
    run_seq(7, 1'b1, "R8");
  endtask

  task automatic t_bubble;
    set_op(0, 16'd10, 16'd10, 1'b0, 32'd5);
    run_seq(1, 1'b0, "R6 single");
    @(negedge clk);
    chk("R6 after gap valid", {31'd0, out_valid}, 32'd0);
    chk("R5 flag without valid", {31'd0, ovf_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_prod_ovf();
    t_add_ovf();
    t_feedback();
    t_bubble();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule